// File: doc/BRIEF.md
# UART Boot Image Loader

This block is the receive side of a serial boot path. It listens on a UART and writes a firmware image into on-chip RAM. A pulse on `start` makes the loader announce itself with STX. It then takes a three-byte header from the host: SOH followed by a 16-bit byte count. If the header is good, it replies with ACK and packs the code bytes into little-endian 32-bit words, writing each word to RAM as soon as it is complete.

After the last code byte, the loader sends a one-byte checksum. It then waits for the host to confirm with ACK. A correct confirmation raises `done`. A wrong confirmation, or a stalled transfer, raises `error`. Either flag holds until the next `start`.

The block contains its own 8N1 UART, at 115200 baud by default. It works over two separate wires or over one shared line. On a shared line, `txEn` tells the pad when to drive, and the receiver ignores the echo of its own transmissions.

Top module: `uart_boot_loader`

## Requirements
- R1: Serial bytes use 8N1 framing. The line idles high. Each frame is a low start bit, eight data bits least significant first, and a high stop bit. Each bit lasts CLKS_PER_BIT clocks, which defaults to CLK_HZ/BAUD, giving 115200 baud from 50 MHz.
- R2: A one-cycle pulse on `start` while idle, done or failed makes the loader transmit 0x02.
- R3: The header is 0x01 followed by the length low byte and then the length high byte. When all three bytes arrive and the first is 0x01, the loader answers 0x06. When the first byte is anything else, it answers 0x15 after the third byte and waits for a new header.
- R4: Once at least one header byte has arrived, a gap of TIMEOUT_CLKS clocks without a further byte makes the loader answer 0x15 and wait for a new header.
- R5: Code byte k is written to word address WORD_BASE + k/4, in bits [8*(k%4)+7 : 8*(k%4)]. Exactly one single-cycle `ramWe` pulse is issued per word, and no write happens outside the code phase.
- R6: When the length is not a multiple of four, the final word is written after its last byte, with the unused upper byte lanes set to zero.
- R7: After the last code byte, the loader transmits 0xFF XOR all code bytes. With a length of zero, it transmits 0xFF straight after the ACK.
- R8: If the host's byte after the checksum is 0x06, `done` rises and stays high. Any other byte raises `error` instead. Both flags are low after reset.
- R9: A gap of TIMEOUT_CLKS clocks while waiting for a code byte or for the final reply raises `error`.
- R10: When `oneWire` is low, `txEn` is always high. When `oneWire` is high, `txEn` is high only while a frame is being sent, and receive data is ignored during that time, so the echo of the loader's own bytes is never taken as host data.
- R11: A new `start` clears `done` and `error` and restarts the exchange.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (single-cycle pulse) |
| oneWire | input | 1 | 1: shared single-line link, 0: separate rx and tx wires |
| rxIn | input | 1 | Serial receive line |
| txOut | output | 1 | Serial transmit line |
| txEn | output | 1 | Pad drive enable for the transmit data |
| ramWe | output | 1 | RAM word write strobe |
| ramAddr | output | ADDR_W | RAM word address |
| ramWdata | output | 32 | RAM write data, little-endian byte packing |
| done | output | 1 | Load confirmed by the host |
| error | output | 1 | Load aborted |

## Verification
One full load uses six code bytes, which separates a full word from a zero-padded partial word. Other images of four and five bytes cover the exact-multiple case and the shared-line case. A bad lead byte and a lone SOH followed by silence each check that a NACK is followed by a clean retry, and a zero-length image shows the checksum seed on its own. A wrong final reply and a stalled code phase separate the two abort paths from a successful finish. Running a complete load on the shared line shows that the echo of every transmitted byte is filtered out, since any echoed byte would corrupt the header.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam logic [7:0] BYTE_STX  = 8'h02;
  localparam logic [7:0] BYTE_SOH  = 8'h01;
  localparam logic [7:0] BYTE_ACK  = 8'h06;
  localparam logic [7:0] BYTE_NAK  = 8'h15;
  localparam logic [7:0] CSUM_SEED = 8'hFF;

  typedef struct packed {
    logic clear;
    logic lenLo;
    logic lenHi;
    logic take;
  } dpCtl_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_STX, ST_HDR, ST_REPLY, ST_DATA, ST_SUM, ST_FINAL, ST_DONE, ST_FAIL
  } ldState_t;
endpackage

// File: rtl/boot_uart_tx.sv
module boot_uart_tx #(
  parameter int CLKS_PER_BIT = 434
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txValid,
  input  logic [7:0] txData,
  output logic       txReady,
  output logic       txBusy,
  output logic       txSerial
);
  localparam int CW = $clog2(CLKS_PER_BIT + 1);

  logic [9:0]    shiftQ;
  logic [3:0]    bitsLeft;
  logic [CW-1:0] tickQ;

  assign txReady  = (bitsLeft == 4'd0);
  assign txBusy   = !txReady;
  assign txSerial = txBusy ? shiftQ[0] : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ   <= '1;
      bitsLeft <= 4'd0;
      tickQ    <= '0;
    end else if (txValid && txReady) begin
      shiftQ   <= {1'b1, txData, 1'b0};
      bitsLeft <= 4'd10;
      tickQ    <= CW'(CLKS_PER_BIT - 1);
    end else if (bitsLeft != 4'd0) begin
      if (tickQ == '0) begin
        shiftQ   <= {1'b1, shiftQ[9:1]};
        bitsLeft <= bitsLeft - 4'd1;
        tickQ    <= CW'(CLKS_PER_BIT - 1);
      end else begin
        tickQ <= tickQ - 1'b1;
      end
    end
  end

  // R1: an accepted byte opens its frame with a low start bit
  a_r1_start_bit_low: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> (txSerial == 1'b0));
endmodule

// File: rtl/boot_uart_rx.sv
module boot_uart_rx #(
  parameter int CLKS_PER_BIT = 434
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLine,
  input  logic       mute,
  output logic       rxValid,
  output logic [7:0] rxData
);
  localparam int CW   = $clog2(CLKS_PER_BIT + 1);
  localparam int HALF = CLKS_PER_BIT / 2;

  logic          s1, s2, line, busy;
  logic [CW-1:0] tickQ;
  logic [3:0]    bitIdx;
  logic [7:0]    shiftQ;

  assign line = mute ? 1'b1 : s2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1 <= 1'b1; s2 <= 1'b1; busy <= 1'b0;
      tickQ <= '0; bitIdx <= 4'd0; shiftQ <= '0;
      rxValid <= 1'b0; rxData <= '0;
    end else begin
      s1 <= rxLine;
      s2 <= s1;
      rxValid <= 1'b0;
      if (!busy) begin
        if (!line) begin
          busy   <= 1'b1;
          tickQ  <= CW'(HALF - 1);
          bitIdx <= 4'd0;
        end
      end else if (tickQ != '0) begin
        tickQ <= tickQ - 1'b1;
      end else if (bitIdx == 4'd0) begin
        if (line) busy <= 1'b0;
        else begin
          bitIdx <= 4'd1;
          tickQ  <= CW'(CLKS_PER_BIT - 1);
        end
      end else if (bitIdx != 4'd9) begin
        shiftQ <= {line, shiftQ[7:1]};
        bitIdx <= bitIdx + 4'd1;
        tickQ  <= CW'(CLKS_PER_BIT - 1);
      end else begin
        busy <= 1'b0;
        if (line) begin
          rxValid <= 1'b1;
          rxData  <= shiftQ;
        end
      end
    end
  end
endmodule

// File: rtl/boot_dp.sv
module boot_dp
  import boot_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int WORD_BASE = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [7:0]        byteIn,
  output logic              allIn,
  output logic              lastByte,
  output logic [7:0]        csum,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [31:0]       ramWdata
);
  logic [7:0]        lenLoQ;
  logic [15:0]       leftQ;
  logic [1:0]        laneQ;
  logic [31:0]       accQ, merged;
  logic [ADDR_W-1:0] wordQ;

  assign allIn    = (leftQ == 16'd0);
  assign lastByte = (leftQ == 16'd1);
  assign merged   = accQ | ({24'b0, byteIn} << {laneQ, 3'b000});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenLoQ <= '0; leftQ <= '0; laneQ <= '0; accQ <= '0; wordQ <= '0;
      csum <= CSUM_SEED; ramWe <= 1'b0; ramAddr <= '0; ramWdata <= '0;
    end else begin
      ramWe <= 1'b0;
      if (ctl.clear) begin
        leftQ <= '0; laneQ <= '0; accQ <= '0; wordQ <= '0; csum <= CSUM_SEED;
      end
      if (ctl.lenLo) lenLoQ <= byteIn;
      if (ctl.lenHi) leftQ <= {byteIn, lenLoQ};
      if (ctl.take) begin
        csum  <= csum ^ byteIn;
        leftQ <= leftQ - 16'd1;
        if (laneQ == 2'd3 || lastByte) begin
          ramWe    <= 1'b1;
          ramAddr  <= ADDR_W'(WORD_BASE) + wordQ;
          ramWdata <= merged;
          accQ     <= '0;
          laneQ    <= 2'd0;
          wordQ    <= wordQ + 1'b1;
        end else begin
          accQ  <= merged;
          laneQ <= laneQ + 2'd1;
        end
      end
    end
  end

  // R5: no code byte is taken beyond the announced length
  a_r5_no_extra_byte: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take |-> !allIn);
  // R5: each word write is a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |=> !ramWe);
endmodule

// File: rtl/boot_ctrl.sv
module boot_ctrl
  import boot_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 1000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  input  logic       txReady,
  output logic       txValid,
  output logic [7:0] txData,
  input  logic       dpAllIn,
  input  logic       dpLast,
  input  logic [7:0] dpCsum,
  output dpCtl_t     ctl,
  output logic       done,
  output logic       error
);
  localparam int TW = $clog2(TIMEOUT_CLKS + 1);

  ldState_t      stQ, stD;
  logic [1:0]    hdrCntQ;
  logic          sohOkQ, hdrGoodQ, watching, timeout;
  logic [TW-1:0] idleQ;

  assign watching = (stQ == ST_HDR && hdrCntQ != 2'd0) || stQ == ST_DATA || stQ == ST_FINAL;
  assign timeout  = watching && (idleQ == TW'(TIMEOUT_CLKS));
  assign done     = (stQ == ST_DONE);
  assign error    = (stQ == ST_FAIL);

  always_comb begin
    stD     = stQ;
    ctl     = '0;
    txValid = 1'b0;
    txData  = BYTE_STX;
    case (stQ)
      ST_IDLE, ST_DONE, ST_FAIL: if (start) begin
        stD = ST_STX;
        ctl.clear = 1'b1;
      end
      ST_STX: begin
        txValid = 1'b1;
        if (txReady) stD = ST_HDR;
      end
      ST_HDR: begin
        if (rxValid) begin
          if (hdrCntQ == 2'd1) ctl.lenLo = 1'b1;
          if (hdrCntQ == 2'd2) begin
            ctl.lenHi = 1'b1;
            stD = ST_REPLY;
          end
        end else if (timeout) stD = ST_REPLY;
      end
      ST_REPLY: begin
        txValid = 1'b1;
        txData  = hdrGoodQ ? BYTE_ACK : BYTE_NAK;
        if (txReady) stD = !hdrGoodQ ? ST_HDR : (dpAllIn ? ST_SUM : ST_DATA);
      end
      ST_DATA: begin
        if (rxValid) begin
          ctl.take = 1'b1;
          if (dpLast) stD = ST_SUM;
        end else if (timeout) stD = ST_FAIL;
      end
      ST_SUM: begin
        txValid = 1'b1;
        txData  = dpCsum;
        if (txReady) stD = ST_FINAL;
      end
      ST_FINAL: begin
        if (rxValid) stD = (rxData == BYTE_ACK) ? ST_DONE : ST_FAIL;
        else if (timeout) stD = ST_FAIL;
      end
      default: stD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ <= ST_IDLE; hdrCntQ <= 2'd0; sohOkQ <= 1'b0; hdrGoodQ <= 1'b0; idleQ <= '0;
    end else begin
      stQ <= stD;
      if (!watching || rxValid || stQ != stD) idleQ <= '0;
      else if (!timeout) idleQ <= idleQ + 1'b1;
      if (ctl.clear) begin
        hdrCntQ <= 2'd0; hdrGoodQ <= 1'b0;
      end else if (stQ == ST_HDR) begin
        if (rxValid) begin
          if (hdrCntQ == 2'd0) sohOkQ <= (rxData == BYTE_SOH);
          if (hdrCntQ == 2'd2) begin
            hdrGoodQ <= sohOkQ;
            hdrCntQ  <= 2'd0;
          end else hdrCntQ <= hdrCntQ + 2'd1;
        end else if (timeout) begin
          hdrGoodQ <= 1'b0;
          hdrCntQ  <= 2'd0;
        end
      end
    end
  end

  // R7: the checksum is only sent once every code byte has been taken
  a_r7_sum_after_all: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_SUM) |-> dpAllIn);
  // R8: success follows a received ACK byte
  a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(rxValid) && $past(rxData) == BYTE_ACK));
  // R8: the two outcome flags never coexist
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));
endmodule

// File: rtl/uart_boot_loader.sv
module uart_boot_loader
  import boot_pkg::*;
#(
  parameter int CLK_HZ       = 50000000,
  parameter int BAUD         = 115200,
  parameter int CLKS_PER_BIT = CLK_HZ / BAUD,
  parameter int TIMEOUT_CLKS = 1000000,
  parameter int ADDR_W       = 12,
  parameter int WORD_BASE    = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              oneWire,
  input  logic              rxIn,
  output logic              txOut,
  output logic              txEn,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [31:0]       ramWdata,
  output logic              done,
  output logic              error
);
  logic       rxValid, txValid, txReady, txBusy, mute, dpAllIn, dpLast;
  logic [7:0] rxData, txData, dpCsum;
  dpCtl_t     ctl;

  assign mute = oneWire && txBusy;
  assign txEn = oneWire ? txBusy : 1'b1;

  boot_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk(clk), .rstN(rstN), .rxLine(rxIn), .mute(mute),
    .rxValid(rxValid), .rxData(rxData));

  boot_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk(clk), .rstN(rstN), .txValid(txValid), .txData(txData),
    .txReady(txReady), .txBusy(txBusy), .txSerial(txOut));

  boot_ctrl #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rxValid(rxValid), .rxData(rxData),
    .txReady(txReady), .txValid(txValid), .txData(txData),
    .dpAllIn(dpAllIn), .dpLast(dpLast), .dpCsum(dpCsum),
    .ctl(ctl), .done(done), .error(error));

  boot_dp #(.ADDR_W(ADDR_W), .WORD_BASE(WORD_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .byteIn(rxData),
    .allIn(dpAllIn), .lastByte(dpLast), .csum(dpCsum),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata));

  // R10: on a shared line nothing is received while the loader drives it
  a_r10_echo_muted: assert property (@(posedge clk) disable iff (!rstN)
    (oneWire && txBusy) |-> !rxValid);
  // R10: the pad is driven whenever a frame is on the wire
  a_r10_drive_while_sending: assert property (@(posedge clk) disable iff (!rstN)
    txBusy |-> txEn);
endmodule

// File: tb/test_uart_boot_loader.sv
module test_uart_boot_loader;
  localparam int CPB  = 8;
  localparam int TMO  = 400;
  localparam int AW   = 12;
  localparam int BASE = 256;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, oneWire = 1'b0, hostTx = 1'b1;
  logic rxIn, txOut, txEn, ramWe, done, error;
  logic [AW-1:0] ramAddr;
  logic [31:0]   ramWdata;

  int checks = 0, errors = 0, devBytes = 0, want = 0;
  logic [7:0]      expTx[$];
  string           expTxTag[$];
  logic [AW+31:0]  expWr[$];
  string           expWrTag[$];

  always #10 clk = ~clk;

  assign rxIn = (oneWire && txEn) ? txOut : hostTx;

  uart_boot_loader #(.CLKS_PER_BIT(CPB), .TIMEOUT_CLKS(TMO), .ADDR_W(AW), .WORD_BASE(BASE))
    i_uart_boot_loader (
      .clk(clk), .rstN(rstN), .start(start), .oneWire(oneWire), .rxIn(rxIn),
      .txOut(txOut), .txEn(txEn), .ramWe(ramWe), .ramAddr(ramAddr),
      .ramWdata(ramWdata), .done(done), .error(error));

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: decode bytes the loader sends and compare against the queue
  initial begin
    logic [7:0] b;
    logic       stopBit;
    forever begin
      @(negedge clk iff (txOut === 1'b0));
      repeat (CPB/2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        repeat (CPB) @(negedge clk);
        b[i] = txOut;
      end
      repeat (CPB) @(negedge clk);
      stopBit = txOut;
      checkEq("R1 stop bit high", {31'b0, stopBit}, 32'd1);
      if (expTx.size() == 0) checkEq("R1 unexpected device byte", {24'b0, b}, 32'hFFFF_FFFF);
      else checkEq(expTxTag.pop_front(), {24'b0, b}, {24'b0, expTx.pop_front()});
      devBytes++;
    end
  end

  // monitor: RAM writes
  initial begin
    logic [AW+31:0] e;
    forever begin
      @(negedge clk);
      if (rstN && ramWe === 1'b1) begin
        if (expWr.size() == 0) checkEq("R5 unexpected write", 32'd1, 32'd0);
        else begin
          e = expWr.pop_front();
          checkEq("R5 write address", {{(32-AW){1'b0}}, ramAddr}, {{(32-AW){1'b0}}, e[AW+31:32]});
          checkEq(expWrTag.pop_front(), ramWdata, e[31:0]);
        end
      end
    end
  end

  task automatic sendByte(input logic [7:0] v);
    hostTx = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      hostTx = v[i];
      repeat (CPB) @(negedge clk);
    end
    hostTx = 1'b1;
    repeat (2*CPB) @(negedge clk);
  endtask

  task automatic devSays(input logic [7:0] v, input string tag);
    expTx.push_back(v);
    expTxTag.push_back(tag);
    want++;
    wait (devBytes >= want);
    repeat (2*CPB) @(negedge clk);
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic sendHeader(input logic [7:0] a, input logic [7:0] lo, input logic [7:0] hi);
    sendByte(a); sendByte(lo); sendByte(hi);
  endtask

  task automatic sendCode(input logic [7:0] code[], output logic [7:0] sum);
    logic [31:0] w;
    sum = 8'hFF;
    w = '0;
    foreach (code[k]) begin
      w[8*(k%4) +: 8] = code[k];
      sum ^= code[k];
      if (k % 4 == 3 || k == code.size() - 1) begin
        expWr.push_back({AW'(BASE + k/4), w});
        expWrTag.push_back((k % 4 == 3) ? "R5 full word data" : "R6 padded word data");
        w = '0;
      end
    end
    foreach (code[k]) sendByte(code[k]);
  endtask

  initial begin
    logic [7:0] sum;
    logic [7:0] img1[] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    logic [7:0] img2[] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    logic [7:0] img3[] = '{8'h0F, 8'hF0, 8'h5A, 8'hA5, 8'h3C};
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 line idles high", {31'b0, txOut}, 32'd1);
    checkEq("R8 done low after reset", {31'b0, done}, 32'd0);
    checkEq("R8 error low after reset", {31'b0, error}, 32'd0);
    checkEq("R5 no write after reset", {31'b0, ramWe}, 32'd0);
    checkEq("R10 txEn high in two-wire mode", {31'b0, txEn}, 32'd1);

    // six bytes: one full word and one padded word
    pulseStart();
    devSays(8'h02, "R2 STX on start");
    sendHeader(8'h01, 8'h06, 8'h00);
    devSays(8'h06, "R3 ACK on good header");
    sendCode(img1, sum);
    devSays(sum, "R7 checksum of six bytes");
    sendByte(8'h06);
    repeat (3*CPB) @(negedge clk);
    checkEq("R8 done after final ACK", {31'b0, done}, 32'd1);
    checkEq("R8 no error after final ACK", {31'b0, error}, 32'd0);

    // bad lead byte, retry, then a wrong final reply
    pulseStart();
    repeat (2) @(negedge clk);
    checkEq("R11 done cleared by start", {31'b0, done}, 32'd0);
    devSays(8'h02, "R2 STX on restart");
    sendHeader(8'h05, 8'h03, 8'h00);
    devSays(8'h15, "R3 NACK on bad lead byte");
    sendHeader(8'h01, 8'h04, 8'h00);
    devSays(8'h06, "R3 ACK after retry");
    sendCode(img2, sum);
    devSays(sum, "R7 checksum of four bytes");
    sendByte(8'h15);
    repeat (3*CPB) @(negedge clk);
    checkEq("R8 error on wrong final reply", {31'b0, error}, 32'd1);
    checkEq("R8 no done on wrong final reply", {31'b0, done}, 32'd0);

    // stalled header, then an empty image
    pulseStart();
    repeat (2) @(negedge clk);
    checkEq("R11 error cleared by start", {31'b0, error}, 32'd0);
    devSays(8'h02, "R2 STX third run");
    sendByte(8'h01);
    devSays(8'h15, "R4 NACK on header stall");
    sendHeader(8'h01, 8'h00, 8'h00);
    devSays(8'h06, "R3 ACK on zero length");
    devSays(8'hFF, "R7 checksum seed for empty image");
    sendByte(8'h06);
    repeat (3*CPB) @(negedge clk);
    checkEq("R8 done for empty image", {31'b0, done}, 32'd1);

    // stalled code phase
    pulseStart();
    devSays(8'h02, "R2 STX fourth run");
    sendHeader(8'h01, 8'h03, 8'h00);
    devSays(8'h06, "R3 ACK before stall");
    sendByte(8'h77);
    repeat (TMO + 100) @(negedge clk);
    checkEq("R9 error on code stall", {31'b0, error}, 32'd1);
    checkEq("R9 no done on code stall", {31'b0, done}, 32'd0);

    // shared single line: echoes must be ignored
    oneWire = 1'b1;
    repeat (2) @(negedge clk);
    checkEq("R10 txEn released when idle", {31'b0, txEn}, 32'd0);
    pulseStart();
    @(negedge clk iff (txOut === 1'b0));
    checkEq("R10 txEn high while sending", {31'b0, txEn}, 32'd1);
    devSays(8'h02, "R10 STX on shared line");
    sendHeader(8'h01, 8'h05, 8'h00);
    devSays(8'h06, "R10 ACK despite echo");
    sendCode(img3, sum);
    devSays(sum, "R10 checksum on shared line");
    sendByte(8'h06);
    repeat (3*CPB) @(negedge clk);
    checkEq("R10 shared-line load completes", {31'b0, done}, 32'd1);

    repeat (4*CPB) @(negedge clk);
    checkEq("R5 every expected write seen", expWr.size(), 32'd0);
    checkEq("R7 every expected byte seen", expTx.size(), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule